// File: doc/BRIEF.md
# Mesochronous link receive FIFO

This block sits at the receiving end of a point-to-point link between two tiles that share a clock frequency but not a clock phase. The sender forwards a 38-bit word together with a strobe that toggles once per core cycle, which makes the strobe a half-rate clock. Each strobe edge carries one word. The receiver captures words into a four-entry ring on both edges of that strobe, and the local clock drains the ring one entry per cycle.

Rising strobe edges fill the even slots and falling edges fill the odd slots, so the two capture banks never share a write clock. The local side notices the first capture after reset. It then waits a separation of one or two local cycles before it starts to read. That separation is picked with a latency-select pin, which is latched only while reset is held. The short setting trades one cycle of latency for a smaller timing margin on the strobe phase.

Once reading has started, the read pointer steps every cycle in lockstep with the writer, and the output valid flag stays high until the next reset.

Top module: `meso_link_rx`

## Requirements
- R1: While `rst` is high across at least one clock edge and at least one rising and one falling strobe edge, `rx_valid` and `rx_flit` read 0 from the cycle after the first such clock edge, and they stay 0 until R5 or R6 releases the first word.
- R2: The first rising strobe edge after reset writes entry 0. Rising edges write even entries and falling edges write odd entries, so consecutive strobe edges fill entries 0, 1, 2, 3 in turn.
- R3: Words appear on `rx_flit` in the order the strobe delivered them, one per clock cycle, and the ring wraps modulo 4 without loss for streams longer than four words.
- R4: While the strobe stays still after reset, `rx_valid` stays 0 and `rx_flit` stays 0, however many cycles pass.
- R5: With `lat_sel` = 0 latched at reset, the word carried by the strobe edge that lands between local clock edges n and n+1 appears on `rx_flit`, with `rx_valid` = 1, after clock edge n+2.
- R6: With `lat_sel` = 1 latched at reset, that word appears after clock edge n+3. This is one cycle later than R5.
- R7: `lat_sel` is sampled only on clock edges where `rst` is high. Changing it after reset does not change the latency.
- R8: Once `rx_valid` rises, it stays high on every cycle until the next reset.
- R9: A reset applied in the middle of a stream drops `rx_valid`. The next stream restarts at entry 0 and uses the latency latched during that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local core clock |
| rst | input | 1 | Synchronous active-high reset; also sampled by the strobe-clocked capture banks |
| lat_sel | input | 1 | Read separation: 0 selects one cycle, 1 selects two cycles; latched during reset |
| lnk_strobe | input | 1 | Forwarded half-rate strobe; both edges capture data |
| lnk_data | input | 38 | Link word, stable around each strobe edge |
| rx_flit | output | 38 | Word read from the ring in local clock time |
| rx_valid | output | 1 | High once reading has started |

## Verification
A write pointer that skips or repeats a slot shows at the ports within four cycles. It appears as a stale or repeated word on `rx_flit`, because every slot is read again one lap later. A read side that starts one cycle early or late moves every output word by one position, so the first valid cycle already miscompares. A latched latency that follows `lat_sel` after reset shifts the stream at the point of the change, which the bench forces in mid-stream. A falling-edge bank that arms before the rising bank puts odd-slot words ahead of even ones in the first lap.

// File: rtl/meso_rx_pkg.sv
`timescale 1ns/1ps
package meso_rx_pkg;

    // default link word width and ring depth
    localparam int LINK_W_DEF = 38;
    localparam int RING_DEF   = 4;

    // longest read separation supported, in local cycles
    localparam int SEP_MAX    = 2;

    typedef enum logic {
        SEP_SHORT = 1'b0,
        SEP_LONG  = 1'b1
    } sep_mode_e;

    // stage of the first-capture shift chain that releases reading
    function automatic int release_stage(sep_mode_e m);
        return (m == SEP_LONG) ? SEP_MAX - 1 : 0;
    endfunction

endpackage

// File: rtl/meso_rx_wr_bank.sv
`timescale 1ns/1ps
module meso_rx_wr_bank #(
    parameter int DATA_W  = meso_rx_pkg::LINK_W_DEF,
    parameter int DEPTH   = meso_rx_pkg::RING_DEF,
    parameter bit ON_FALL = 1'b0
) (
    input  logic                              strb,
    input  logic                              rst,
    input  logic                              arm_i,
    input  logic [DATA_W-1:0]                 din,
    output logic [DATA_W*(DEPTH/2)-1:0]       bank_o,
    output logic                              began_o
);
    localparam int SLOTS  = DEPTH / 2;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOT_W-1:0] wp_q;

    // one bank per strobe edge; the variant is picked by ON_FALL
    generate
        if (ON_FALL) begin : g_fall
            always_ff @(negedge strb) begin
                if (rst) begin
                    wp_q    <= '0;
                    began_o <= 1'b0;
                end else if (arm_i) begin
                    slot_q[wp_q] <= din;
                    wp_q         <= wp_q + 1'b1;
                    began_o      <= 1'b1;
                end
            end
        end else begin : g_rise
            always_ff @(posedge strb) begin
                if (rst) begin
                    wp_q    <= '0;
                    began_o <= 1'b0;
                end else if (arm_i) begin
                    slot_q[wp_q] <= din;
                    wp_q         <= wp_q + 1'b1;
                    began_o      <= 1'b1;
                end
            end
        end
    endgenerate

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_flat
            assign bank_o[i*DATA_W +: DATA_W] = slot_q[i];
        end
    endgenerate

endmodule

// File: rtl/meso_rx_rd.sv
`timescale 1ns/1ps
module meso_rx_rd
    import meso_rx_pkg::*;
#(
    parameter int DATA_W = LINK_W_DEF,
    parameter int DEPTH  = RING_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_i,
    input  logic                    began_i,
    input  logic [DATA_W*DEPTH-1:0] ring_i,
    output logic [DATA_W-1:0]       flit_o,
    output logic                    valid_o
);
    localparam int PTR_W = $clog2(DEPTH);

    sep_mode_e         mode_q;
    logic [SEP_MAX-1:0] seen_q;
    logic [PTR_W-1:0]   rp_q;
    logic               go;
    logic [DATA_W-1:0]  ent [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            assign ent[e] = ring_i[e*DATA_W +: DATA_W];
        end
    endgenerate

    // reading starts once the first capture has crossed the chosen number of stages
    assign go = seen_q[release_stage(mode_q)];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= sep_mode_e'(sel_i);
            seen_q  <= '0;
            rp_q    <= '0;
            valid_o <= 1'b0;
            flit_o  <= '0;
        end else begin
            seen_q <= {seen_q[SEP_MAX-2:0], began_i};
            if (valid_o || go) begin
                flit_o  <= ent[rp_q];
                rp_q    <= rp_q + 1'b1;
                valid_o <= 1'b1;
            end
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst) valid_o |=> valid_o); // R8
    AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (rst) !seen_q[0] |=> !valid_o); // R4
    AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst) $rose(valid_o) |-> rp_q == PTR_W'(1)); // R3
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst) !rst |=> $stable(mode_q)); // R7

endmodule

// File: rtl/meso_link_rx.sv
`timescale 1ns/1ps
module meso_link_rx
    import meso_rx_pkg::*;
#(
    parameter int DATA_W = LINK_W_DEF,
    parameter int DEPTH  = RING_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_sel,
    input  logic              lnk_strobe,
    input  logic [DATA_W-1:0] lnk_data,
    output logic [DATA_W-1:0] rx_flit,
    output logic              rx_valid
);
    localparam int SLOTS = DEPTH / 2;

    logic [DATA_W*SLOTS-1:0] even_bank;
    logic [DATA_W*SLOTS-1:0] odd_bank;
    logic [DATA_W*DEPTH-1:0] ring;
    logic                    rise_began;
    logic                    fall_began;

    meso_rx_wr_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ON_FALL(1'b0)) u_even (
        .strb    (lnk_strobe),
        .rst     (rst),
        .arm_i   (1'b1),
        .din     (lnk_data),
        .bank_o  (even_bank),
        .began_o (rise_began)
    );

    // falling edges write only after the first rising edge has written entry 0
    meso_rx_wr_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ON_FALL(1'b1)) u_odd (
        .strb    (lnk_strobe),
        .rst     (rst),
        .arm_i   (rise_began),
        .din     (lnk_data),
        .bank_o  (odd_bank),
        .began_o (fall_began)
    );

    // interleave the banks back into ring order
    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ring
            if (e % 2 == 0) begin : g_even
                assign ring[e*DATA_W +: DATA_W] = even_bank[(e/2)*DATA_W +: DATA_W];
            end else begin : g_odd
                assign ring[e*DATA_W +: DATA_W] = odd_bank[(e/2)*DATA_W +: DATA_W];
            end
        end
    endgenerate

    meso_rx_rd #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (lat_sel),
        .began_i (rise_began),
        .ring_i  (ring),
        .flit_o  (rx_flit),
        .valid_o (rx_valid)
    );

    AST_ODD_AFTER_EVEN: assert property (@(posedge clk) disable iff (rst) fall_began |-> rise_began); // R2

endmodule

// File: tb/meso_link_rx_test.sv
`timescale 1ns/1ps
module meso_link_rx_test;

    localparam int W = 38;

    typedef struct packed {
        logic        sel;
        logic [3:0]  phase;
        logic [7:0]  words;
        logic [7:0]  idle;
        logic        flip;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd6, 8'd9,  8'd0, 1'b0, 32'h1234_0001},
        '{1'b1, 4'd6, 8'd9,  8'd0, 1'b0, 32'hC0DE_0002},
        '{1'b0, 4'd3, 8'd7,  8'd4, 1'b1, 32'h0BAD_0003},
        '{1'b1, 4'd3, 8'd11, 8'd2, 1'b1, 32'h7777_0004},
        '{1'b0, 4'd5, 8'd6,  8'd0, 1'b0, 32'hFACE_0005}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         lat_sel = 1'b0;
    logic         lnk_strobe = 1'b0;
    logic [W-1:0] lnk_data = '0;
    logic [W-1:0] rx_flit;
    logic         rx_valid;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    meso_link_rx uut (
        .clk        (clk),
        .rst        (rst),
        .lat_sel    (lat_sel),
        .lnk_strobe (lnk_strobe),
        .lnk_data   (lnk_data),
        .rx_flit    (rx_flit),
        .rx_valid   (rx_valid)
    );

    function automatic logic [W-1:0] word(int k, logic [31:0] seed);
        logic [31:0] lo;
        lo = seed ^ (32'(k) * 32'h9E37_79B9);
        return {6'(k) + seed[5:0], lo};
    endfunction

    task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // reset while the strobe runs, leave it low, release rst at a falling clock edge
    task automatic do_reset(input logic sel, input bool_mid);
        @(negedge clk);
        rst = 1'b1;
        lat_sel = sel;
        lnk_data = '0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #6 lnk_strobe = ~lnk_strobe;
        end
        if (lnk_strobe) begin
            @(posedge clk);
            #6 lnk_strobe = 1'b0;
        end
        @(posedge clk);
        #2;
        if (bool_mid) chk("R9 valid dropped by reset", {rx_valid, rx_flit}, '0);
        else          chk("R1 reset state", {rx_valid, rx_flit}, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        for (int v = 0; v < NV; v++) begin
            int lat;
            int ph;
            do_reset(VECS[v].sel, v > 0);
            lat = VECS[v].sel ? 3 : 2;
            ph  = int'(VECS[v].phase);
            for (int i = 0; i < int'(VECS[v].idle); i++) begin
                @(posedge clk);
                #2 chk("R4 idle link", {rx_valid, rx_flit}, '0);
            end
            for (int c = 0; c < int'(VECS[v].words) + lat; c++) begin
                @(posedge clk);
                #1 lnk_data = word(c, VECS[v].seed);
                #1;
                if (c < lat)
                    chk("R4 R1 before release", {rx_valid, rx_flit}, '0);
                else if (VECS[v].flip && c >= 3)
                    chk("R7 latency held", {rx_valid, rx_flit}, {1'b1, word(c - lat, VECS[v].seed)});
                else if (VECS[v].sel)
                    chk("R6 R3 R2 R8 long", {rx_valid, rx_flit}, {1'b1, word(c - lat, VECS[v].seed)});
                else
                    chk("R5 R3 R2 R8 short", {rx_valid, rx_flit}, {1'b1, word(c - lat, VECS[v].seed)});
                if (VECS[v].flip && c == 3) lat_sel = ~VECS[v].sel;
                #(ph - 2) lnk_strobe = ~lnk_strobe;
            end
        end
        // back-to-back reset after the last stream
        do_reset(1'b0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule